// File: doc/BRIEF.md
# CAN Acceptance Filter Bank Array

This block sits behind a CAN frame parser and decides, for each received identifier, whether the frame is kept. For a kept frame it also chooses one of two receive queues and produces a filter match index that tells software which filter accepted the frame. A parsed frame arrives as a 29-bit identifier field, an extended-format flag and a remote-request flag, qualified by a one-cycle valid strobe. The result appears one clock later.

The filter banks are configured through a write-only register port. Each bank holds a control nibble and two 32-bit words. The control nibble carries an enable, a scale, a mode and a queue assignment. Depending on scale and mode, a bank acts as one 32-bit masked filter, two 32-bit exact identifiers, two 16-bit masked filters or four 16-bit exact identifiers. In list mode the second word stops being a mask and becomes a second identifier. Two controllers share the banks. A split register gives the banks below its value to the first controller and the remaining banks to the second. Each frame carries a port bit that selects which controller's banks are searched.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every bank is disabled, every word is zero, the split value is 14, and res_valid and res_accept are low. Any frame sent before configuration is rejected.
- R2: A frame presented with frm_valid at a clock edge yields res_valid high during the following cycle only, with res_accept, res_fifo and res_index for that frame. res_accept is never high without res_valid. A rejected frame reports res_fifo 0 and res_index 0.
- R3: Register map. cfg_addr = bank*4 + sel: sel 0 is the control nibble (bit0 enable, bit1 32-bit scale, bit2 list mode, bit3 queue 1), sel 1 is the first word and sel 2 is the second word. Address NUM_BANKS*4 loads the split value from the low bits of cfg_wdata.
- R4: The 32-bit key is {stid[10:0], exid[17:0], ide, rtr, 1'b0}. For a standard frame, stid is frm_id[10:0] and exid is zero. For an extended frame, stid is frm_id[28:18] and exid is frm_id[17:0]. A 32-bit masked bank accepts when ((key ^ word1_first) & word_second) == 0: a mask bit of 1 requires equality, a mask bit of 0 is don't-care. An all-zero mask accepts everything, and an all-ones mask accepts exactly one key.
- R5: A 32-bit list bank accepts a key equal to the first word (position 0) or to the second word (position 1).
- R6: The 16-bit key is {stid[10:0], rtr, ide, exid[17:15]}. A 16-bit masked bank has two filters. Position 0 uses identifier first[15:0] with mask first[31:16]. Position 1 uses identifier second[15:0] with mask second[31:16].
- R7: A 16-bit list bank has four exact identifiers. Positions 0 to 3 are first[15:0], first[31:16], second[15:0] and second[31:16].
- R8: A bank at 16-bit scale never accepts an extended frame.
- R9: A disabled bank accepts nothing. With every bank disabled, every frame is rejected.
- R10: A frame with frm_port 0 is matched only against banks below the split value. A frame with frm_port 1 is matched only against banks at or above it.
- R11: res_fifo equals the queue bit of the bank that accepted the frame.
- R12: When several filters match, the lowest-numbered bank wins. Within that bank, the lowest position wins.
- R13: res_index is the winning position plus the filter count of every enabled bank below the winner that lies in the same controller's range and is assigned to the same queue. Filter counts are 1 for 32-bit mask, 2 for 32-bit list, 2 for 16-bit mask and 4 for 16-bit list.
- R14: A configuration write in the same cycle as a frame does not affect that frame's result. It applies from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (7) | Configuration address, bank*4 + select, or NUM_BANKS*4 for the split |
| cfg_wdata | input | 32 | Configuration write data |
| frm_valid | input | 1 | Parsed frame strobe |
| frm_port | input | 1 | Controller that received the frame (0 first, 1 second) |
| frm_id | input | 29 | Identifier; standard frames use bits [10:0] |
| frm_ide | input | 1 | Extended-format frame |
| frm_rtr | input | 1 | Remote request frame |
| res_valid | output | 1 | Result present for the previous cycle's frame |
| res_accept | output | 1 | Frame accepted |
| res_fifo | output | 1 | Receive queue for an accepted frame |
| res_index | output | IDX_W (7) | Filter match index |

## Verification
A configuration write and a frame lookup can occur in the same cycle. The bench provokes this by raising cfg_we and frm_valid on the same edge, disabling the very bank that would accept the frame. It judges the outcome by expecting that frame to be accepted under the old setting and the next identical frame to be rejected. Several banks matching one frame in the same cycle is the other collision. Directed overlapping banks and random configurations drawn from a small identifier pool provoke it. The bench checks the winning bank, queue and index against a bench model built from the requirements.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  // Control nibble of one bank; en is bit 0, fifo1 is bit 3
  typedef struct packed {
    logic fifo1;
    logic list;
    logic scale32;
    logic en;
  } bank_ctrl_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_WA   = 2'd1;
  localparam logic [1:0] SEL_WB   = 2'd2;

  function automatic logic [10:0] std_part(input logic [28:0] id, input logic ide);
    return ide ? id[28:18] : id[10:0];
  endfunction

  function automatic logic [17:0] ext_part(input logic [28:0] id, input logic ide);
    return ide ? id[17:0] : 18'd0;
  endfunction

  // 32-bit comparison key: std id, ext id, ide, rtr, zero
  function automatic logic [31:0] make_key32(input logic [28:0] id, input logic ide,
                                             input logic rtr);
    return {std_part(id, ide), ext_part(id, ide), ide, rtr, 1'b0};
  endfunction

  // 16-bit comparison key: std id, rtr, ide, top three ext bits
  function automatic logic [15:0] make_key16(input logic [28:0] id, input logic ide,
                                             input logic rtr);
    logic [17:0] ex;
    ex = ext_part(id, ide);
    return {std_part(id, ide), rtr, ide, ex[17:15]};
  endfunction

endpackage

// File: rtl/can_filt_cfg.sv
module can_filt_cfg
  import can_filt_pkg::*;
#(
  parameter int NUM_BANKS     = 28,
  parameter int DEFAULT_SPLIT = 14,
  parameter int ADDR_W        = $clog2(NUM_BANKS * 4 + 1),
  parameter int SPLIT_W       = $clog2(NUM_BANKS + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [31:0]                   wdata,
  output bank_ctrl_t [NUM_BANKS-1:0]    ctrl,
  output logic [NUM_BANKS-1:0][31:0]    word_a,
  output logic [NUM_BANKS-1:0][31:0]    word_b,
  output logic [SPLIT_W-1:0]            split
);

  localparam int BANK_W = ADDR_W - 2;
  localparam int SPLIT_ADDR = NUM_BANKS * 4;

  logic [BANK_W-1:0] sel_bank;
  logic [1:0]        sel_field;
  logic              bank_hit;
  logic              split_hit;

  assign sel_bank  = addr[ADDR_W-1:2];
  assign sel_field = addr[1:0];
  assign bank_hit  = we && (int'(sel_bank) < NUM_BANKS);
  assign split_hit = we && (int'(addr) == SPLIT_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      word_a <= '0;
      word_b <= '0;
      split  <= SPLIT_W'(DEFAULT_SPLIT);
    end else begin
      if (bank_hit) begin
        unique case (sel_field)
          SEL_CTRL: ctrl[sel_bank]   <= bank_ctrl_t'(wdata[3:0]);
          SEL_WA:   word_a[sel_bank] <= wdata;
          SEL_WB:   word_b[sel_bank] <= wdata;
          default:  ;
        endcase
      end
      if (split_hit) split <= wdata[SPLIT_W-1:0];
    end
  end

endmodule

// File: rtl/can_filt_bank.sv
module can_filt_bank
  import can_filt_pkg::*;
(
  input  bank_ctrl_t  ctrl,
  input  logic [31:0] word_a,
  input  logic [31:0] word_b,
  input  logic [31:0] key32,
  input  logic [15:0] key16,
  input  logic        ide,
  output logic        hit,
  output logic [1:0]  pos,
  output logic [2:0]  nflt
);

  logic [3:0] h;

  always_comb begin
    h    = '0;
    nflt = 3'd4;
    unique case ({ctrl.scale32, ctrl.list})
      2'b10: begin
        nflt = 3'd1;
        h[0] = ((key32 ^ word_a) & word_b) == 32'd0;
      end
      2'b11: begin
        nflt = 3'd2;
        h[0] = key32 == word_a;
        h[1] = key32 == word_b;
      end
      2'b00: begin
        nflt = 3'd2;
        h[0] = !ide && (((key16 ^ word_a[15:0]) & word_a[31:16]) == 16'd0);
        h[1] = !ide && (((key16 ^ word_b[15:0]) & word_b[31:16]) == 16'd0);
      end
      default: begin
        nflt = 3'd4;
        h[0] = !ide && (key16 == word_a[15:0]);
        h[1] = !ide && (key16 == word_a[31:16]);
        h[2] = !ide && (key16 == word_b[15:0]);
        h[3] = !ide && (key16 == word_b[31:16]);
      end
    endcase
    if (!ctrl.en) h = '0;
  end

  assign hit = |h;
  assign pos = h[0] ? 2'd0 : h[1] ? 2'd1 : h[2] ? 2'd2 : 2'd3;

endmodule

// File: rtl/can_filt_resolve.sv
module can_filt_resolve #(
  parameter int NUM_BANKS = 28,
  parameter int SPLIT_W   = $clog2(NUM_BANKS + 1),
  parameter int IDX_W     = $clog2(NUM_BANKS * 4)
) (
  input  logic [NUM_BANKS-1:0]       hit_vec,
  input  logic [NUM_BANKS-1:0]       en_vec,
  input  logic [NUM_BANKS-1:0]       fifo_vec,
  input  logic [NUM_BANKS-1:0][1:0]  pos_vec,
  input  logic [NUM_BANKS-1:0][2:0]  nflt_vec,
  input  logic [SPLIT_W-1:0]         split,
  input  logic                       port,
  output logic                       found,
  output logic                       fifo,
  output logic [IDX_W-1:0]           idx
);

  always_comb begin : walk
    logic [IDX_W-1:0] cnt0;
    logic [IDX_W-1:0] cnt1;
    logic             inr;
    cnt0  = '0;
    cnt1  = '0;
    found = 1'b0;
    fifo  = 1'b0;
    idx   = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      inr = port ? (b >= int'(split)) : (b < int'(split));
      if (inr && en_vec[b]) begin
        if (hit_vec[b] && !found) begin
          found = 1'b1;
          fifo  = fifo_vec[b];
          idx   = (fifo_vec[b] ? cnt1 : cnt0) + IDX_W'(pos_vec[b]);
        end
        if (fifo_vec[b]) cnt1 = cnt1 + IDX_W'(nflt_vec[b]);
        else             cnt0 = cnt0 + IDX_W'(nflt_vec[b]);
      end
    end
  end

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int NUM_BANKS     = 28,
  parameter int DEFAULT_SPLIT = 14,
  parameter int ADDR_W        = $clog2(NUM_BANKS * 4 + 1),
  parameter int IDX_W         = $clog2(NUM_BANKS * 4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              frm_valid,
  input  logic              frm_port,
  input  logic [28:0]       frm_id,
  input  logic              frm_ide,
  input  logic              frm_rtr,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_fifo,
  output logic [IDX_W-1:0]  res_index
);

  localparam int SPLIT_W = $clog2(NUM_BANKS + 1);

  bank_ctrl_t [NUM_BANKS-1:0]       ctrl;
  logic [NUM_BANKS-1:0][31:0]       word_a;
  logic [NUM_BANKS-1:0][31:0]       word_b;
  logic [SPLIT_W-1:0]               split;

  logic [31:0] key32;
  logic [15:0] key16;

  logic [NUM_BANKS-1:0]      hit_vec;
  logic [NUM_BANKS-1:0]      bank_en;
  logic [NUM_BANKS-1:0]      bank_s32;
  logic [NUM_BANKS-1:0]      bank_fifo;
  logic [NUM_BANKS-1:0][1:0] pos_vec;
  logic [NUM_BANKS-1:0][2:0] nflt_vec;

  logic             found;
  logic             win_fifo;
  logic [IDX_W-1:0] win_idx;

  can_filt_cfg #(
    .NUM_BANKS(NUM_BANKS), .DEFAULT_SPLIT(DEFAULT_SPLIT),
    .ADDR_W(ADDR_W), .SPLIT_W(SPLIT_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .word_a(word_a), .word_b(word_b), .split(split)
  );

  assign key32 = make_key32(frm_id, frm_ide, frm_rtr);
  assign key16 = make_key16(frm_id, frm_ide, frm_rtr);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_en[b]   = ctrl[b].en;
    assign bank_s32[b]  = ctrl[b].scale32;
    assign bank_fifo[b] = ctrl[b].fifo1;
    can_filt_bank u_bank (
      .ctrl(ctrl[b]), .word_a(word_a[b]), .word_b(word_b[b]),
      .key32(key32), .key16(key16), .ide(frm_ide),
      .hit(hit_vec[b]), .pos(pos_vec[b]), .nflt(nflt_vec[b])
    );
  end

  can_filt_resolve #(
    .NUM_BANKS(NUM_BANKS), .SPLIT_W(SPLIT_W), .IDX_W(IDX_W)
  ) u_resolve (
    .hit_vec(hit_vec), .en_vec(bank_en), .fifo_vec(bank_fifo),
    .pos_vec(pos_vec), .nflt_vec(nflt_vec), .split(split), .port(frm_port),
    .found(found), .fifo(win_fifo), .idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_fifo   <= 1'b0;
      res_index  <= '0;
    end else begin
      res_valid  <= frm_valid;
      res_accept <= frm_valid && found;
      if (frm_valid) begin
        res_fifo  <= found ? win_fifo : 1'b0;
        res_index <= found ? win_idx : '0;
      end
    end
  end

endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int NUM_BANKS = 28
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 frm_valid,
  input logic                 frm_ide,
  input logic                 res_valid,
  input logic                 res_accept,
  input logic [NUM_BANKS-1:0] en_vec,
  input logic [NUM_BANKS-1:0] s32_vec
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && !res_accept));

  // R2
  result_latency_chk: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> res_valid);

  // R2
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> !res_valid);

  // R2
  accept_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    res_accept |-> res_valid);

  // R9
  all_disabled_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && (en_vec == '0)) |=> !res_accept);

  // R8
  ext_needs_wide_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_ide && ((en_vec & s32_vec) == '0)) |=> !res_accept);

endmodule

bind can_accept_filter can_accept_filter_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ide(frm_ide),
  .res_valid(res_valid), .res_accept(res_accept),
  .en_vec(bank_en), .s32_vec(bank_s32)
);

// File: tb/can_accept_filter_test.sv
`timescale 1ns/1ps
module can_accept_filter_test;

  localparam int NB = 28;
  localparam int AW = $clog2(NB * 4 + 1);
  localparam int IW = $clog2(NB * 4);
  localparam logic [3:0] C_M32 = 4'b0011, C_L32 = 4'b0111,
                         C_M16 = 4'b0001, C_L16 = 4'b0101, Q1 = 4'b1000;

  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic frm_valid = 0, frm_port = 0, frm_ide = 0, frm_rtr = 0;
  logic [28:0] frm_id = '0;
  logic res_valid, res_accept, res_fifo;
  logic [IW-1:0] res_index;

  always #4 clk = ~clk;

  can_accept_filter uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frm_valid(frm_valid), .frm_port(frm_port), .frm_id(frm_id), .frm_ide(frm_ide),
    .frm_rtr(frm_rtr), .res_valid(res_valid), .res_accept(res_accept),
    .res_fifo(res_fifo), .res_index(res_index)
  );

  int n_chk = 0, n_fail = 0;
  logic [3:0]  m_ctrl [NB];
  logic [31:0] m_wa [NB];
  logic [31:0] m_wb [NB];
  int m_split = 14;
  logic got_valid, got_acc, got_fifo;
  int   got_idx;

  function automatic logic [31:0] s32(input logic [10:0] sid, input bit rtr);
    return {sid, 18'd0, 1'b0, rtr, 1'b0};
  endfunction
  function automatic logic [31:0] x32(input logic [28:0] id, input bit rtr);
    return {id, 1'b1, rtr, 1'b0};
  endfunction
  function automatic logic [15:0] s16(input logic [10:0] sid, input bit rtr);
    return {sid, rtr, 4'b0};
  endfunction

  // Expected result derived from the requirements
  function automatic void model(input bit port, input logic [28:0] id, input bit ide,
                                input bit rtr, output bit acc, output bit q, output int idx);
    logic [31:0] k32;
    logic [15:0] k16;
    int cnt [2];
    bit h [4];
    int n;
    cnt[0] = 0; cnt[1] = 0; acc = 0; q = 0; idx = 0;
    k32 = ide ? x32(id, rtr) : s32(id[10:0], rtr);
    k16 = ide ? {id[28:18], rtr, 1'b1, id[17:15]} : s16(id[10:0], rtr);
    for (int b = 0; b < NB; b++) begin
      bit inr;
      inr = port ? (b >= m_split) : (b < m_split);
      if (inr && m_ctrl[b][0]) begin
        for (int p = 0; p < 4; p++) h[p] = 0;
        case (m_ctrl[b][2:1])
          2'b01: begin n = 1; h[0] = ((k32 ^ m_wa[b]) & m_wb[b]) == 0; end
          2'b11: begin n = 2; h[0] = k32 == m_wa[b]; h[1] = k32 == m_wb[b]; end
          2'b00: begin
            n = 2;
            h[0] = !ide && (((k16 ^ m_wa[b][15:0]) & m_wa[b][31:16]) == 0);
            h[1] = !ide && (((k16 ^ m_wb[b][15:0]) & m_wb[b][31:16]) == 0);
          end
          default: begin
            n = 4;
            h[0] = !ide && k16 == m_wa[b][15:0];
            h[1] = !ide && k16 == m_wa[b][31:16];
            h[2] = !ide && k16 == m_wb[b][15:0];
            h[3] = !ide && k16 == m_wb[b][31:16];
          end
        endcase
        for (int p = 0; p < 4; p++)
          if (!acc && p < n && h[p]) begin
            acc = 1; q = m_ctrl[b][3]; idx = cnt[m_ctrl[b][3]] + p;
          end
        cnt[m_ctrl[b][3]] += n;
      end
    end
  endfunction

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(bank * 4 + sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (sel == 0) m_ctrl[bank] = d[3:0];
    else if (sel == 1) m_wa[bank] = d;
    else m_wb[bank] = d;
  endtask

  task automatic bank_set(input int bank, input logic [3:0] c, input logic [31:0] a,
                          input logic [31:0] b);
    wr(bank, 1, a); wr(bank, 2, b); wr(bank, 0, {28'd0, c});
  endtask

  task automatic wr_split(input int v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(NB * 4); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0; m_split = v;
  endtask

  task automatic send(input bit port, input logic [28:0] id, input bit ide, input bit rtr);
    @(negedge clk);
    frm_valid = 1; frm_port = port; frm_id = id; frm_ide = ide; frm_rtr = rtr;
    @(negedge clk);
    frm_valid = 0;
    got_valid = res_valid; got_acc = res_accept; got_fifo = res_fifo; got_idx = int'(res_index);
  endtask

  task automatic expect_res(input string tag, input bit acc, input bit q, input int idx);
    chk({tag, " valid"}, got_valid == 1, got_valid, 1);
    chk({tag, " accept"}, got_acc == acc, got_acc, acc);
    if (acc) begin
      chk({tag, " fifo"}, got_fifo == q, got_fifo, q);
      chk({tag, " index"}, got_idx == idx, got_idx, idx);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] pick(input logic [10:0] ps [8], input logic [28:0] pe [4]);
    case ($urandom % 6)
      0: return s32(ps[$urandom % 8], 1'($urandom % 2));
      1: return x32(pe[$urandom % 4], 1'b0);
      2: return {s16(ps[$urandom % 8], 0), s16(ps[$urandom % 8], 0)};
      3: return {16'hFF00, s16(ps[$urandom % 8], 0)};
      4: return 32'hFFE0_0000;
      default: return $urandom & $urandom;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    finish_up();
  end

  initial begin
    logic [10:0] ps [8];
    logic [28:0] pe [4];
    bit ea, eq;
    int ei;
    void'($urandom(32'd2024));
    for (int b = 0; b < NB; b++) begin m_ctrl[b] = 0; m_wa[b] = 0; m_wb[b] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 res_valid idle", res_valid == 0, res_valid, 0);

    // R1 / R9: unconfigured -> reject
    send(0, 29'h123, 0, 0); expect_res("R1 R9 reset reject", 0, 0, 0);
    send(1, 29'h123, 0, 0); expect_res("R1 split14 port1 reject", 0, 0, 0);

    // R3 R4: 32-bit mask, range 0x200..0x2FF
    bank_set(0, C_M32, s32(11'h200, 0), {11'h700, 21'd0});
    send(0, 29'h2A5, 0, 0); expect_res("R4 mask in range", 1, 0, 0);
    send(0, 29'h3A5, 0, 0); expect_res("R4 mask out of range", 0, 0, 0);
    send(0, 29'h250, 0, 1); expect_res("R4 rtr dont care", 1, 0, 0);
    wr(0, 2, 32'hFFFF_FFFF);
    send(0, 29'h200, 0, 0); expect_res("R4 all ones exact", 1, 0, 0);
    send(0, 29'h201, 0, 0); expect_res("R4 all ones other", 0, 0, 0);
    wr(0, 2, 32'h0);
    send(0, 29'h1ABCDEF, 1, 0); expect_res("R4 zero mask extended", 1, 0, 0);

    // R5 R11: 32-bit list on queue 1
    bank_set(0, C_L32 | Q1, s32(11'h181, 0), s32(11'h281, 0));
    send(0, 29'h281, 0, 0); expect_res("R5 R11 list second", 1, 1, 1);
    send(0, 29'h181, 0, 0); expect_res("R5 list first", 1, 1, 0);
    send(0, 29'h381, 0, 0); expect_res("R5 list miss", 0, 0, 0);

    // R7 R8: 16-bit list
    bank_set(0, C_L16, {s16(11'h101, 0), s16(11'h100, 0)}, {s16(11'h201, 0), s16(11'h200, 0)});
    send(0, 29'h201, 0, 0); expect_res("R7 list16 pos3", 1, 0, 3);
    send(0, 29'h100, 0, 0); expect_res("R7 list16 pos0", 1, 0, 0);
    send(0, {11'h100, 18'd0}, 1, 0); expect_res("R8 list16 extended", 0, 0, 0);

    // R6 R8: 16-bit mask
    bank_set(0, C_M16, {16'hE000, s16(11'h200, 0)}, {16'hFFE0, s16(11'h7DF, 0)});
    send(0, 29'h2AA, 0, 0); expect_res("R6 mask16 pos0", 1, 0, 0);
    send(0, 29'h7DF, 0, 0); expect_res("R6 mask16 pos1", 1, 0, 1);
    send(0, 29'h7DE, 0, 0); expect_res("R6 mask16 miss", 0, 0, 0);
    send(0, {11'h2AA, 18'd0}, 1, 0); expect_res("R8 mask16 extended", 0, 0, 0);

    // R9: disable
    wr(0, 0, 32'h0);
    send(0, 29'h2AA, 0, 0); expect_res("R9 disabled bank", 0, 0, 0);

    // R12 R13: overlapping banks
    bank_set(0, C_L16, {s16(11'h011, 0), s16(11'h010, 0)}, {s16(11'h013, 0), s16(11'h012, 0)});
    bank_set(1, C_M32 | Q1, 0, 0);
    bank_set(2, C_L32, s32(11'h500, 0), s32(11'h010, 0));
    bank_set(3, C_M32, 0, 0);
    send(0, 29'h012, 0, 0); expect_res("R12 lowest bank pos2", 1, 0, 2);
    send(0, 29'h500, 0, 0); expect_res("R12 R11 bank1 wins", 1, 1, 0);
    wr(1, 0, 32'h0);
    send(0, 29'h500, 0, 0); expect_res("R13 index after list16", 1, 0, 4);
    send(0, 29'h010, 0, 0); expect_res("R12 lowest position", 1, 0, 0);
    send(0, 29'h777, 0, 0); expect_res("R13 index accumulates", 1, 0, 6);

    // R10: split
    send(1, 29'h012, 0, 0); expect_res("R10 port1 no banks", 0, 0, 0);
    bank_set(14, C_M32 | Q1, 0, 0);
    send(1, 29'h012, 0, 0); expect_res("R10 R13 port1 bank14", 1, 1, 0);
    wr_split(15);
    send(1, 29'h012, 0, 0); expect_res("R10 split moved", 0, 0, 0);
    wr(3, 0, 32'h0);
    bank_set(1, C_L32 | Q1, s32(11'h601, 0), s32(11'h602, 0));
    send(0, 29'h7AB, 0, 0); expect_res("R10 R13 bank14 now port0", 1, 1, 2);
    wr_split(14);

    // R14: write and frame in the same cycle
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(14 * 4); cfg_wdata = 0;
    frm_valid = 1; frm_port = 1; frm_id = 29'h012; frm_ide = 0; frm_rtr = 0;
    @(negedge clk);
    cfg_we = 0; frm_valid = 0;
    got_valid = res_valid; got_acc = res_accept; got_fifo = res_fifo; got_idx = int'(res_index);
    m_ctrl[14] = 0;
    expect_res("R14 old config used", 1, 1, 0);
    send(1, 29'h012, 0, 0); expect_res("R14 new config next", 0, 0, 0);

    // Random configurations against the model
    for (int k = 0; k < 8; k++) ps[k] = 11'($urandom);
    for (int k = 0; k < 4; k++) pe[k] = 29'($urandom);
    for (int r = 0; r < 8; r++) begin
      for (int b = 0; b < NB; b++) begin
        logic [3:0] c;
        c = 4'($urandom);
        c[0] = ($urandom % 10) >= 3;
        bank_set(b, c, pick(ps, pe), pick(ps, pe));
      end
      wr_split($urandom % (NB + 1));
      for (int f = 0; f < 40; f++) begin
        bit port, ide, rtr;
        logic [28:0] id;
        port = 1'($urandom % 2);
        ide  = ($urandom % 3) == 0;
        rtr  = ($urandom % 5) == 0;
        id   = ide ? pe[$urandom % 4] : 29'(ps[$urandom % 8]);
        if ($urandom % 4 == 0) id[0] = ~id[0];
        model(port, id, ide, rtr, ea, eq, ei);
        send(port, id, ide, rtr);
        expect_res("R4-model R12 R13 random", ea, eq, ei);
      end
    end

    finish_up();
  end

endmodule